// File: doc/BRIEF.md
# Two-Tier Strip Coincidence Unit

This block sits behind the discriminators of a two-layer silicon strip tracker. It serves 64 strip sets. Each set has one long strip, which measures phi, and five short strips, which measure z. All six strips in a set lie at the same phi position. The discriminator outputs arrive asynchronously. Each one passes through a two-flop synchronizer and is then captured in a sticky latch. The latch holds the hit until the readout logic has shifted it out and pulses `clear`.

The five short-strip levels of a set are ORed into one bottom-tier hit. A per-set state machine compares the rising edge of the long-strip (top-tier) hit with the rising edge of the bottom-tier hit. When the two edges arrive at most `win_cfg` clock cycles apart, in either order, the set records a coincidence, called a track stub. Three chip-wide fast-OR flags report whether any long-strip hit, any short-strip hit or any coincidence is currently latched.

The per-set machine has four states:
- `CO_IDLE`: no edge is pending.
- `CO_TOP_WAIT`: a top edge has been seen and the machine waits for a bottom edge.
- `CO_BOT_WAIT`: a bottom edge has been seen and the machine waits for a top edge.
- `CO_MATCH`: a coincidence is latched.

It has these transitions:
- `both_edges`: IDLE to MATCH, when both edges arrive in the same cycle.
- `top_first`: IDLE to TOP_WAIT.
- `bot_first`: IDLE to BOT_WAIT.
- `pair_in_window`: WAIT to MATCH.
- `window_expired`: WAIT to IDLE.
- `clear_all`: any state to IDLE.

When the window is 0, a lone edge leaves the machine in IDLE.

Top module: `coinc_top`

## Requirements
- R1: While reset is held and after it is released, every latched bit (`phi_lat`, `z_lat`, `coinc_lat`) and every fast-OR flag is 0.
- R2: A long-strip input that goes high is shown on `phi_lat[s]` at the third rising clock edge after the change, and not before. It stays set until a clear.
- R3: Each short-strip input `z_raw[s*5+k]` (k = 0..4) is latched into its own bit `z_lat[s*5+k]` and stays set until a clear.
- R4: A rising edge on any one of the five short strips of a set counts as that set's bottom-tier hit.
- R5: `coinc_lat[s]` is set when the long-strip edge and the bottom-tier edge of set s occur d cycles apart, with d ≤ `win_cfg`, whichever edge comes first. It stays 0 when d > `win_cfg`.
- R6: With `win_cfg` = 0, only edges in the same cycle form a coincidence.
- R7: Once `coinc_lat[s]` is set, it stays set until a clear, and further hits do not change it.
- R8: A `clear` sampled at a clock edge empties all latches and returns every set to idle. All fast-OR flags are 0 in the cycle after the clear.
- R9: `any_phi`, `any_z` and `any_coinc` are the ORs of `phi_lat`, `z_lat` and `coinc_lat`.
- R10: Sets are independent. A long-strip hit in one set and a short-strip hit in another set form no coincidence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Synchronous clear of all latches, pulsed after readout |
| win_cfg | input | 3 | Coincidence window in cycles (0..7) |
| phi_raw | input | 64 | Asynchronous long-strip discriminator outputs, one per set |
| z_raw | input | 320 | Asynchronous short-strip discriminator outputs, bit s*5+k |
| phi_lat | output | 64 | Latched long-strip hits |
| z_lat | output | 320 | Latched short-strip hits |
| coinc_lat | output | 64 | Latched coincidence hits |
| any_phi | output | 1 | Fast-OR of all long-strip latches |
| any_z | output | 1 | Fast-OR of all short-strip latches |
| any_coinc | output | 1 | Fast-OR of all coincidence latches |

## Verification
The assertions check on every cycle that the latches are sticky between clears, that a coincidence never appears without both tier latches of its set, that the flags are empty one cycle after a clear, and that the coincidence flag implies both tier flags. Only the bench scenarios can show the window itself: a pair of edges exactly `win_cfg` apart matches, one cycle more does not, and both arrival orders behave alike. The bench scenarios also show the exact three-edge latency of the synchronizer and the independence of neighbouring sets.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
    typedef enum logic [1:0] {
        CO_IDLE     = 2'd0,
        CO_TOP_WAIT = 2'd1,
        CO_BOT_WAIT = 2'd2,
        CO_MATCH    = 2'd3
    } co_state_t;
endpackage

// File: rtl/hit_sync.sv
module hit_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] old_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            old_q  <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            old_q  <= sync_q;
        end
    end

    assign lvl  = sync_q;
    assign prev = old_q;
endmodule

// File: rtl/coinc_fsm.sv
module coinc_fsm
    import coinc_pkg::*;
#(
    parameter int WIN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [WIN_W-1:0] win,
    input  logic             top_rise,
    input  logic             bot_rise,
    output logic             match
);
    co_state_t        state_q, state_d;
    logic [WIN_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CO_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and window counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (clear) begin
            state_d = CO_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                CO_IDLE: begin
                    cnt_d = WIN_W'(1);
                    if (top_rise && bot_rise)         state_d = CO_MATCH;
                    else if (win == '0)               state_d = CO_IDLE;
                    else if (top_rise)                state_d = CO_TOP_WAIT;
                    else if (bot_rise)                state_d = CO_BOT_WAIT;
                end
                CO_TOP_WAIT: begin
                    if (bot_rise && cnt_q <= win)     state_d = CO_MATCH;
                    else if (cnt_q >= win)            state_d = CO_IDLE;
                    else                              cnt_d   = cnt_q + WIN_W'(1);
                end
                CO_BOT_WAIT: begin
                    if (top_rise && cnt_q <= win)     state_d = CO_MATCH;
                    else if (cnt_q >= win)            state_d = CO_IDLE;
                    else                              cnt_d   = cnt_q + WIN_W'(1);
                end
                CO_MATCH: state_d = CO_MATCH;
                default:  state_d = CO_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        match = (state_q == CO_MATCH);
    end
endmodule

// File: rtl/strip_set.sv
module strip_set #(
    parameter int NZ    = 5,
    parameter int WIN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [WIN_W-1:0] win,
    input  logic             phi_lvl,
    input  logic             phi_prev,
    input  logic [NZ-1:0]    z_lvl,
    input  logic [NZ-1:0]    z_prev,
    output logic             phi_lat,
    output logic [NZ-1:0]    z_lat,
    output logic             coinc
);
    logic top_rise;
    logic bot_rise;

    assign top_rise = phi_lvl & ~phi_prev;
    assign bot_rise = (|z_lvl) & ~(|z_prev);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            phi_lat <= 1'b0;
            z_lat   <= '0;
        end else begin
            phi_lat <= phi_lat | phi_lvl;
            z_lat   <= z_lat | z_lvl;
        end
    end

    coinc_fsm #(.WIN_W(WIN_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .win      (win),
        .top_rise (top_rise),
        .bot_rise (bot_rise),
        .match    (coinc)
    );
endmodule

// File: rtl/coinc_top.sv
module coinc_top #(
    parameter int NSETS = 64,
    parameter int NZ    = 5,
    parameter int WIN_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic [WIN_W-1:0]    win_cfg,
    input  logic [NSETS-1:0]    phi_raw,
    input  logic [NSETS*NZ-1:0] z_raw,
    output logic [NSETS-1:0]    phi_lat,
    output logic [NSETS*NZ-1:0] z_lat,
    output logic [NSETS-1:0]    coinc_lat,
    output logic                any_phi,
    output logic                any_z,
    output logic                any_coinc
);
    localparam int NZT = NSETS * NZ;

    logic [NSETS-1:0] phi_lvl, phi_prev;
    logic [NZT-1:0]   z_lvl, z_prev;

    hit_sync #(.W(NSETS)) u_phi_sync (
        .clk (clk), .rst_n (rst_n), .raw (phi_raw),
        .lvl (phi_lvl), .prev (phi_prev)
    );

    hit_sync #(.W(NZT)) u_z_sync (
        .clk (clk), .rst_n (rst_n), .raw (z_raw),
        .lvl (z_lvl), .prev (z_prev)
    );

    for (genvar s = 0; s < NSETS; s++) begin : g_set
        strip_set #(.NZ(NZ), .WIN_W(WIN_W)) u_set (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (clear),
            .win      (win_cfg),
            .phi_lvl  (phi_lvl[s]),
            .phi_prev (phi_prev[s]),
            .z_lvl    (z_lvl[s*NZ +: NZ]),
            .z_prev   (z_prev[s*NZ +: NZ]),
            .phi_lat  (phi_lat[s]),
            .z_lat    (z_lat[s*NZ +: NZ]),
            .coinc    (coinc_lat[s])
        );
    end

    assign any_phi   = |phi_lat;
    assign any_z     = |z_lat;
    assign any_coinc = |coinc_lat;
endmodule

// File: rtl/coinc_chk.sv
module coinc_chk #(
    parameter int NSETS = 64,
    parameter int NZ    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                clear,
    input logic [NSETS-1:0]    phi_lat,
    input logic [NSETS*NZ-1:0] z_lat,
    input logic [NSETS-1:0]    coinc_lat,
    input logic                any_phi,
    input logic                any_z,
    input logic                any_coinc
);
    logic [NSETS-1:0] bot_any;
    always_comb begin
        for (int s = 0; s < NSETS; s++) bot_any[s] = |z_lat[s*NZ +: NZ];
    end

    // R7
    coinc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((coinc_lat & $past(coinc_lat)) == $past(coinc_lat)));

    // R2
    phi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((phi_lat & $past(phi_lat)) == $past(phi_lat)));

    // R3
    z_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((z_lat & $past(z_lat)) == $past(z_lat)));

    // R8
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!any_phi && !any_z && !any_coinc));

    // R5
    coinc_needs_tiers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coinc_lat & ~(phi_lat & bot_any)) == '0);

    // R9
    flag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_coinc |-> (any_phi && any_z));
endmodule

bind coinc_top coinc_chk #(.NSETS(NSETS), .NZ(NZ)) u_coinc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .phi_lat   (phi_lat),
    .z_lat     (z_lat),
    .coinc_lat (coinc_lat),
    .any_phi   (any_phi),
    .any_z     (any_z),
    .any_coinc (any_coinc)
);

// File: tb/tb_coinc_top.sv
module tb_coinc_top;
    localparam int NSETS = 64;
    localparam int NZ    = 5;
    localparam int NV    = 11;

    // vector table: set, short strip, delay (phi first if >= 0), window, expected coincidence
    localparam int V_SET [NV] = '{0, 1, 2, 5, 6, 7, 10, 20, 63, 40, 33};
    localparam int V_Z   [NV] = '{0, 2, 4, 1, 3, 0, 2, 4, 1, 3, 0};
    localparam int V_DLY [NV] = '{0, 0, 3, -3, 4, -4, 1, 7, -7, 8, 2};
    localparam int V_WIN [NV] = '{0, 3, 3, 3, 3, 3, 0, 7, 7, 7, 2};
    localparam int V_EXP [NV] = '{1, 1, 1, 1, 0, 0, 0, 1, 1, 0, 1};

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                clear = 1'b0;
    logic [2:0]          win_cfg = 3'd0;
    logic [NSETS-1:0]    phi_raw = '0;
    logic [NSETS*NZ-1:0] z_raw = '0;
    logic [NSETS-1:0]    phi_lat;
    logic [NSETS*NZ-1:0] z_lat;
    logic [NSETS-1:0]    coinc_lat;
    logic                any_phi, any_z, any_coinc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    coinc_top dut (
        .clk (clk), .rst_n (rst_n), .clear (clear), .win_cfg (win_cfg),
        .phi_raw (phi_raw), .z_raw (z_raw),
        .phi_lat (phi_lat), .z_lat (z_lat), .coinc_lat (coinc_lat),
        .any_phi (any_phi), .any_z (any_z), .any_coinc (any_coinc)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic flush();
        phi_raw = '0;
        z_raw   = '0;
        repeat (4) @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_vec(input int s, input int k, input int d, input int w, input int e);
        int mag;
        mag = (d < 0) ? -d : d;
        win_cfg = 3'(w);
        @(negedge clk);
        if (d >= 0) phi_raw[s] = 1'b1; else z_raw[s*NZ+k] = 1'b1;
        repeat (mag) @(negedge clk);
        phi_raw[s] = 1'b1;
        z_raw[s*NZ+k] = 1'b1;
        repeat (12) @(negedge clk);
        chk((w == 0) ? "R6 window zero" : "R5 window match", 64'(coinc_lat[s]), 64'(e));
        chk("R2 phi latched", 64'(phi_lat[s]), 64'd1);
        chk("R3 z latched", 64'(z_lat[s*NZ+k]), 64'd1);
        chk("R4 one strip gives bottom hit", 64'(coinc_lat), 64'(e) << s);
        chk("R9 any_coinc", 64'(any_coinc), 64'(e));
        flush();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset coinc", 64'(coinc_lat), 64'd0);
        chk("R1 reset flags", {61'd0, any_phi, any_z, any_coinc}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 after reset phi", 64'(phi_lat), 64'd0);

        for (int i = 0; i < NV; i++) begin
            run_vec(V_SET[i], V_Z[i], V_DLY[i], V_WIN[i], V_EXP[i]);
        end

        // R2 latency: phi latched at the third edge, not the second
        phi_raw[9] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 not yet after two edges", 64'(phi_lat[9]), 64'd0);
        @(negedge clk);
        chk("R2 set after three edges", 64'(phi_lat[9]), 64'd1);
        flush();

        // R10 independent sets, R9 flags
        win_cfg = 3'd7;
        phi_raw[3] = 1'b1;
        z_raw[4*NZ+2] = 1'b1;
        repeat (12) @(negedge clk);
        chk("R10 no cross-set coinc", 64'(coinc_lat), 64'd0);
        chk("R9 flags phi z no coinc", {61'd0, any_phi, any_z, any_coinc}, 64'b110);
        flush();

        // R7 sticky, further hits ignored
        win_cfg = 3'd1;
        phi_raw[12] = 1'b1;
        z_raw[12*NZ] = 1'b1;
        repeat (8) @(negedge clk);
        chk("R7 match formed", 64'(coinc_lat[12]), 64'd1);
        phi_raw[12] = 1'b0;
        z_raw[12*NZ] = 1'b0;
        repeat (6) @(negedge clk);
        phi_raw[12] = 1'b1;
        repeat (12) @(negedge clk);
        chk("R7 holds after inputs toggle", 64'(coinc_lat[12]), 64'd1);

        // R8 clear empties everything the following cycle
        phi_raw = '0;
        z_raw   = '0;
        repeat (4) @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        chk("R8 flags empty after clear", {61'd0, any_phi, any_z, any_coinc}, 64'd0);
        chk("R8 coinc empty after clear", 64'(coinc_lat), 64'd0);
        repeat (8) @(negedge clk);
        chk("R8 stays empty", 64'(z_lat[63:0]), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule